// File: doc/BRIEF.md
# Board control shift-register driver

This block keeps an 8-bit board control byte in a local shadow register and sends it to an external serial-in, parallel-out latch. The latch is fed from the clock and data wires of an I2C bus, plus one strobe wire. Each transfer has three parts. First the byte is shifted out, highest bit first, with one clock rise per bit. Next a single strobe pulse copies the shift stage into the latch outputs. Last, the shared wires are left high, so that an I2C START can follow at once.

The byte can be changed in three ways: per-bit set and clear masks, a whole-byte write, or a plain re-send trigger. Any of these queues a full transfer. Requests that arrive while a transfer is running are merged into the shadow. When the running transfer ends, exactly one more transfer follows with the merged value.

A transfer starts only while the bus grant input is high. The clock/data output enable is high only while a transfer runs. Every line change is followed by a hold time of `HOLD_CYC` clock cycles before the next change, which keeps the wire timing slow enough for the latch.

Top module: `ctl_shift_drv`

## Requirements
- R1: After reset, `scl_o`=1, `sda_o`=1, `str_o`=0, `bus_oe_o`=0 and `busy_o`=0. The shadow holds 0xCC (bits 2, 3, 6 and 7 set: both DTR_n bits, PCI reset_n and EEPROM write-control_n), and a transfer of it is already pending.
- R2: A transfer carries exactly 8 bits, bit 7 first. For each bit, SCL goes low, then SDA takes the bit, then SCL rises, and the rise is the shift edge. SDA never changes while SCL is high during a transfer.
- R3: After the eighth SCL rise, STR goes high and then low, exactly once per transfer. SCL stays high while STR is high.
- R4: After the strobe, the driver drives SCL low, then SDA high, then SCL high. Whenever the block is idle, SCL=1, SDA=1 and STR=0.
- R5: At most one line changes per cycle. Successive line changes inside a transfer are at least `HOLD_CYC` cycles apart, and the spacing is always a whole multiple of `HOLD_CYC`.
- R6: `set_i[k]` sets bit k and `clr_i[k]` clears bit k. If both are asserted for the same bit, the clear wins. No other bit changes, and the whole byte is re-sent.
- R7: A `wr_en_i` pulse replaces the shadow with `wr_data_i`. Set and clear masks given in the same cycle apply on top of the written value. A transfer follows.
- R8: An `upd_i` pulse with no other request re-sends the unchanged shadow.
- R9: Requests made during a transfer update the shadow. Exactly one further transfer then carries the final merged value.
- R10: A transfer starts only in a cycle where `grant_i` is high. `bus_oe_o` is high exactly while `busy_o` is high.
- R11: A transfer keeps `busy_o` high for exactly 29·`HOLD_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | DATA_W | Per-bit set request mask |
| clr_i | input | DATA_W | Per-bit clear request mask |
| wr_en_i | input | 1 | Whole-byte write strobe |
| wr_data_i | input | DATA_W | Whole-byte write value |
| upd_i | input | 1 | Re-send request |
| grant_i | input | 1 | Shared-bus grant from the arbiter |
| scl_o | output | 1 | Shared clock line drive value |
| sda_o | output | 1 | Shared data line drive value |
| str_o | output | 1 | Latch strobe |
| bus_oe_o | output | 1 | Output enable for SCL and SDA |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- the lines are parked while the block is idle;
- SDA is stable while SCL is high;
- STR is high only with SCL high;
- at most one line changes per cycle, with the minimum hold spacing between changes;
- grant-gated starts, and output enable tracking busy.

Other behaviour is visible only across whole scenarios, and the bench's scenarios cover it:
- the bit order and the value each transfer carries;
- clear-over-set priority and the combination of write and masks;
- merging of requests made mid-transfer into exactly one follow-up transfer;
- the pending transfer from reset waiting for a grant.

// File: rtl/ctl_shift_pkg.sv
package ctl_shift_pkg;
  localparam int unsigned CTL_W = 8;

  localparam int unsigned BIT_CLK_INT0 = 0;
  localparam int unsigned BIT_CLK_INT1 = 1;
  localparam int unsigned BIT_DTR0_N   = 2;
  localparam int unsigned BIT_DTR1_N   = 3;
  localparam int unsigned BIT_EXT      = 4;
  localparam int unsigned BIT_AUTO_RST = 5;
  localparam int unsigned BIT_PCIRST_N = 6;
  localparam int unsigned BIT_WC_N     = 7;

  localparam logic [CTL_W-1:0] CTL_INIT =
      CTL_W'((1 << BIT_DTR0_N) | (1 << BIT_DTR1_N) |
             (1 << BIT_PCIRST_N) | (1 << BIT_WC_N));

  // line-change steps of one transfer
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLK_LO,
    ST_DAT,
    ST_CLK_HI,
    ST_STB_HI,
    ST_STB_LO,
    ST_PK_CLK_LO,
    ST_PK_DAT_HI,
    ST_PK_CLK_HI
  } step_e;
endpackage

// File: rtl/ctl_shadow_reg.sv
module ctl_shadow_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         upd_i,
  input  logic         start_i,
  output logic [W-1:0] shadow_o,
  output logic         pend_o
);
  logic [W-1:0] shadow_q, shadow_d;
  logic         pend_q;
  logic         req;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic base;
    assign base        = wr_en_i ? wr_data_i[k] : shadow_q[k];
    // clear has priority over set
    assign shadow_d[k] = (base | set_i[k]) & ~clr_i[k];
  end

  assign req = wr_en_i | upd_i | (|set_i) | (|clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= INIT;
      pend_q   <= 1'b1;
    end else begin
      shadow_q <= shadow_d;
      if (req)          pend_q <= 1'b1;
      else if (start_i) pend_q <= 1'b0;
    end
  end

  assign shadow_o = shadow_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/ctl_hold_timer.sv
module ctl_hold_timer #(
  parameter int unsigned HOLD_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= RELOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ctl_frame_seq.sv
module ctl_frame_seq
  import ctl_shift_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pend_i,
  input  logic         grant_i,
  input  logic [W-1:0] data_i,
  input  logic         tick_i,
  output logic         start_o,
  output logic         load_o,
  output logic         scl_o,
  output logic         sda_o,
  output logic         str_o,
  output logic         oe_o,
  output logic         busy_o
);
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(W - 1);

  step_e            st_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     snap_q;
  logic             scl_q, sda_q, str_q, oe_q;
  logic             start, adv;

  assign start = (st_q == ST_IDLE) && pend_i && grant_i;
  assign adv   = (st_q != ST_IDLE) && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= IDX_TOP;
      snap_q <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      str_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start) begin
      st_q   <= ST_CLK_LO;
      snap_q <= data_i;
      idx_q  <= IDX_TOP;
      scl_q  <= 1'b0;
      oe_q   <= 1'b1;
    end else if (adv) begin
      unique case (st_q)
        ST_CLK_LO: begin
          st_q  <= ST_DAT;
          sda_q <= snap_q[idx_q];
        end
        ST_DAT: begin
          st_q  <= ST_CLK_HI;
          scl_q <= 1'b1;
        end
        ST_CLK_HI: begin
          if (idx_q == '0) begin
            st_q  <= ST_STB_HI;
            str_q <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
            st_q  <= ST_CLK_LO;
            scl_q <= 1'b0;
          end
        end
        ST_STB_HI: begin
          st_q  <= ST_STB_LO;
          str_q <= 1'b0;
        end
        ST_STB_LO: begin
          st_q  <= ST_PK_CLK_LO;
          scl_q <= 1'b0;
        end
        ST_PK_CLK_LO: begin
          st_q  <= ST_PK_DAT_HI;
          sda_q <= 1'b1;
        end
        ST_PK_DAT_HI: begin
          st_q  <= ST_PK_CLK_HI;
          scl_q <= 1'b1;
        end
        ST_PK_CLK_HI: begin
          st_q <= ST_IDLE;
          oe_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o = start;
  assign load_o  = start | adv;
  assign scl_o   = scl_q;
  assign sda_o   = sda_q;
  assign str_o   = str_q;
  assign oe_o    = oe_q;
  assign busy_o  = (st_q != ST_IDLE);
endmodule

// File: rtl/ctl_shift_drv.sv
module ctl_shift_drv
  import ctl_shift_pkg::*;
#(
  parameter int unsigned       DATA_W   = CTL_W,
  parameter int unsigned       HOLD_CYC = 300,
  parameter logic [DATA_W-1:0] INIT_VAL = DATA_W'(CTL_INIT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              upd_i,
  input  logic              grant_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              str_o,
  output logic              bus_oe_o,
  output logic              busy_o
);
  logic [DATA_W-1:0] shadow;
  logic              pend, start, load, tick;

  ctl_shadow_reg #(.W(DATA_W), .INIT(INIT_VAL)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_i),
    .clr_i     (clr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .upd_i     (upd_i),
    .start_i   (start),
    .shadow_o  (shadow),
    .pend_o    (pend)
  );

  ctl_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .expired_o (tick)
  );

  ctl_frame_seq #(.W(DATA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .grant_i (grant_i),
    .data_i  (shadow),
    .tick_i  (tick),
    .start_o (start),
    .load_o  (load),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .str_o   (str_o),
    .oe_o    (bus_oe_o),
    .busy_o  (busy_o)
  );
endmodule

// File: rtl/ctl_shift_drv_chk.sv
module ctl_shift_drv_chk #(
  parameter int unsigned HOLD_CYC = 300
) (
  input logic clk_i,
  input logic rst_ni,
  input logic grant_i,
  input logic scl_o,
  input logic sda_o,
  input logic str_o,
  input logic bus_oe_o,
  input logic busy_o
);
  localparam int unsigned GAP_W = $clog2(HOLD_CYC + 2);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(HOLD_CYC);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(HOLD_CYC - 1);

  logic             scl_p, sda_p, str_p, busy_p;
  logic [GAP_W-1:0] gap_q;
  logic             chg;

  assign chg = (scl_o != scl_p) || (sda_o != sda_p) || (str_o != str_p);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      str_p  <= 1'b0;
      busy_p <= 1'b0;
      gap_q  <= '0;
    end else begin
      scl_p  <= scl_o;
      sda_p  <= sda_o;
      str_p  <= str_o;
      busy_p <= busy_o;
      if (chg)                  gap_q <= '0;
      else if (gap_q < GAP_MAX) gap_q <= gap_q + 1'b1;
    end
  end

  assert_idle_parked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && sda_o && !str_o));

  assert_sda_stable_clk_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (sda_o != sda_p)) |-> !scl_o);

  assert_strobe_clk_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    str_o |-> (scl_o && bus_oe_o));

  assert_one_line_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({scl_o ^ scl_p, sda_o ^ sda_p, str_o ^ str_p}) <= 1);

  assert_hold_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && busy_p) |-> (gap_q >= GAP_MIN));

  assert_start_needs_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(grant_i));

  assert_oe_tracks_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o == busy_o);
endmodule

bind ctl_shift_drv ctl_shift_drv_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .grant_i  (grant_i),
  .scl_o    (scl_o),
  .sda_o    (sda_o),
  .str_o    (str_o),
  .bus_oe_o (bus_oe_o),
  .busy_o   (busy_o)
);

// File: tb/tb_ctl_shift_drv.sv
module tb_ctl_shift_drv;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 3;
  localparam int W          = 8;
  localparam int FRAME_LEN  = 29 * HOLD;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] set_m = '0, clr_m = '0, wr_d = '0;
  logic         wr_en = 1'b0, upd = 1'b0, grant = 1'b0;
  logic         scl, sda, str, oe, busy;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] model;
  int frames = 0, frames_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_shift_drv #(.DATA_W(W), .HOLD_CYC(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_m), .clr_i(clr_m),
    .wr_en_i(wr_en), .wr_data_i(wr_d), .upd_i(upd), .grant_i(grant),
    .scl_o(scl), .sda_o(sda), .str_o(str), .bus_oe_o(oe), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // driver: apply one request cycle and queue the expected transfer
  task automatic request(input logic [W-1:0] s, input logic [W-1:0] c,
                         input logic we, input logic [W-1:0] d,
                         input logic u, input bit push);
    @(negedge clk);
    set_m = s; clr_m = c; wr_en = we; wr_d = d; upd = u;
    model = ((we ? d : model) | s) & ~c;
    @(negedge clk);
    set_m = '0; clr_m = '0; wr_en = 1'b0; upd = 1'b0;
    if (push) begin
      exp_q.push_back(model);
      frames_exp++;
    end
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  // monitor
  logic scl_p = 1'b1, sda_p = 1'b1, str_p = 1'b0, oe_p = 1'b0;
  int   cyc = 0, last_chg = 0, oe_start = 0, bitcnt = 0;
  bit   strobed = 1'b0;
  logic [W-1:0] cap = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] dv;
      cyc++;
      dv = {scl ^ scl_p, sda ^ sda_p, str ^ str_p};
      if (dv != 3'b000) begin
        chk($countones(dv) == 1, "R5 one line per change", $countones(dv), 1);
        if (oe_p) chk((cyc - last_chg) >= HOLD && ((cyc - last_chg) % HOLD) == 0,
                      "R5 hold spacing", cyc - last_chg, HOLD);
        last_chg = cyc;
      end
      if (oe && !oe_p) begin
        chk(grant, "R10 start with grant", grant, 1);
        oe_start = cyc; bitcnt = 0; strobed = 1'b0;
      end
      if (oe && sda != sda_p) chk(!scl, "R2 sda moves with scl low", scl, 0);
      if (oe && scl && !scl_p && !strobed) begin
        cap = {cap[W-2:0], sda};
        bitcnt++;
      end
      if (str && !str_p) begin
        chk(bitcnt == W && !strobed, "R2 bit count at strobe", bitcnt, W);
        chk(scl, "R3 scl high at strobe", scl, 1);
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected transfer", cap, 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(cap == e, "R2/R6/R7/R8/R9 latched byte", cap, e);
        end
        strobed = 1'b1;
      end
      if (!oe && oe_p) begin
        frames++;
        chk(strobed, "R3 strobe seen", strobed, 1);
        chk(scl && sda && !str, "R4 parked after transfer", {scl, sda, str}, 3'b110);
        chk((cyc - oe_start) == FRAME_LEN, "R11 transfer length", cyc - oe_start, FRAME_LEN);
      end
      chk(oe == busy, "R10 oe equals busy", oe, busy);
      scl_p = scl; sda_p = sda; str_p = str; oe_p = oe;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model = 8'hCC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, no grant yet so the pending transfer waits
    repeat (20) @(negedge clk);
    chk(scl && sda && !str, "R1 reset lines", {scl, sda, str}, 3'b110);
    chk(!oe && !busy, "R1 idle without grant", {oe, busy}, 0);
    chk(frames == 0, "R10 no transfer without grant", frames, 0);
    // R1 initial byte goes out once granted
    exp_q.push_back(8'hCC); frames_exp++;
    grant = 1'b1;
    wait_idle();
    // R6 set bit 0
    request(8'h01, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1); wait_idle();
    // R6 clear bit 7
    request(8'h00, 8'h80, 1'b0, 8'h00, 1'b0, 1'b1); wait_idle();
    // R7 whole write
    request(8'h00, 8'h00, 1'b1, 8'hA5, 1'b0, 1'b1); wait_idle();
    // R7 write plus masks, R6 clear beats set on bit 1
    request(8'h82, 8'h03, 1'b1, 8'h0F, 1'b0, 1'b1); wait_idle();
    chk(model == 8'h8C, "R6 model clear-wins value", model, 8'h8C);
    // R8 plain re-send
    request(8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1); wait_idle();
    // R9 merge during a transfer
    request(8'h00, 8'h00, 1'b1, 8'h11, 1'b0, 1'b1);
    while (!busy) @(negedge clk);
    repeat (10) @(negedge clk);
    request(8'h40, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    request(8'h00, 8'h10, 1'b0, 8'h00, 1'b0, 1'b1);
    wait_idle();
    chk(model == 8'h41, "R9 merged model", model, 8'h41);
    // R10 request with grant low waits
    grant = 1'b0;
    request(8'h20, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    repeat (3 * FRAME_LEN) @(negedge clk);
    chk(!busy && !oe, "R10 held off without grant", {busy, oe}, 0);
    chk(frames == frames_exp - 1, "R10 transfer count while held", frames, frames_exp - 1);
    grant = 1'b1;
    wait_idle();
    chk(exp_q.size() == 0, "R9 all expected transfers seen", exp_q.size(), 0);
    chk(frames == frames_exp, "R9 transfer count", frames, frames_exp);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule